// File: doc/BRIEF.md
# Programmable Counter Timebase with Interrupt Combiner

This block is a 16-bit free-running up-counter. It serves as the shared timebase for a bank of capture/compare channels. Its count source is chosen by software from six options:

- the system clock, either directly or divided by 4 or by 12;
- a timer overflow pulse;
- a synchronized external counting input;
- a synchronized external clock divided by 8.

The live count goes out on a parallel bus to the channels. Software can also read it through a byte-wide register port. Reading the low byte freezes a copy of the high byte, so a two-byte read stays coherent while the counter keeps running.

The block keeps eight sticky event flags:

- a full-width wrap flag;
- an intermediate wrap flag, whose tap point can be moved between counter bits 8 and 11;
- six channel flags, fed as single-cycle pulses by the channel logic outside the block.

Every flag sets on its event regardless of any enable. The single interrupt line is raised only when a flag and its own enable are both set, and both a global enable and a block enable are on.

Top module: `tick_counter_irq`

## Requirements
- R1: After reset the counter is 0x0000, and register reads return 0 at the control (address 2), flag (address 3), enable (address 4) and global (address 5) locations. The interrupt output is low.
- R2: Control register (address 2) layout: bits [2:0] source select, bit 3 run, bits [5:4] tap select. With source 100 (system clock) and run set, the counter rises by one on every clock. With run clear, the counter holds its value.
- R3: Source 000 divides the system clock by 12. A control write that changes the source select restarts the prescaler, so the first count comes 12 clocks after the write edge.
- R4: Source 001 divides the system clock by 4, with the same restart on a select change; the first count comes 4 clocks after the write edge.
- R5: Source 010 advances the counter once for every clock cycle in which the timer overflow input is high.
- R6: Source 011 advances the counter once per rising edge of the external counting input, after a two-stage synchronizer.
- R7: Source 101 advances the counter once per eight synchronized rising edges of the external clock input.
- R8: A read of address 0 returns the counter low byte and copies the live high byte into a snapshot. A read of address 1 returns that snapshot, not the live high byte.
- R9: When the counter steps from 0xFFFF to 0x0000, flag bit 0 (flag register, address 3) is set.
- R10: Flag bit 1 is set when the counter steps while its low N bits are all ones. N is 8, 9, 10 or 11 for tap select 00, 01, 10 or 11.
- R11: Flag bits [7:2] are set by pulses on channel event inputs 0 to 5. Every flag sets on its event whether or not its enable is on.
- R12: Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. When an event and a clearing write hit the same bit in the same cycle, the bit ends set.
- R13: The interrupt output is high exactly when all three conditions hold:
  - some flag bit and the same bit of the enable register (address 4) are both 1;
  - global register (address 5) bit 0 (global enable) is 1;
  - global register bit 1 (block enable) is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (snapshot side effect) |
| addr | input | 3 | Register address |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read data |
| timerOvf | input | 1 | Timer overflow pulse, system clock domain |
| extCount | input | 1 | Asynchronous external counting input |
| extClk | input | 1 | Asynchronous external clock input |
| chEvt | input | 6 | Channel event pulses |
| count | output | 16 | Live counter value to the channels |
| irq | output | 1 | Combined interrupt request |

## Verification
The assertions check these properties on every cycle:
- the counter steps by exactly one on each enabled tick and holds otherwise;
- both wrap strobes leave their flag set, and a full wrap lands on zero;
- flags stay set unless software writes the flag register;
- the interrupt line stays low whenever either global enable is off or no enabled flag is set.

Only the bench scenarios can show the following:
- the tick rate of each clock source, and that the prescaler restarts on a select change;
- the synchronizer latency on the external inputs;
- the snapshot coherence across a carry into the high byte;
- that the tap select moves the intermediate flag;
- that a set event beats a clearing write in the same cycle.

// File: rtl/tcb_pkg.sv
`timescale 1ns/1ps
package tcb_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int CNT_W  = 2 * BYTE_W;

  // count source select codes
  localparam logic [2:0] SRC_SYS_DIV12 = 3'b000;
  localparam logic [2:0] SRC_SYS_DIV4  = 3'b001;
  localparam logic [2:0] SRC_TMR_OVF   = 3'b010;
  localparam logic [2:0] SRC_EXT_CNT   = 3'b011;
  localparam logic [2:0] SRC_SYS       = 3'b100;
  localparam logic [2:0] SRC_EXT_DIV8  = 3'b101;

  // register addresses
  localparam logic [ADDR_W-1:0] REG_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] REG_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] REG_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] REG_FLAG   = 3'd3;
  localparam logic [ADDR_W-1:0] REG_EN     = 3'd4;
  localparam logic [ADDR_W-1:0] REG_GLB    = 3'd5;

  // control -> datapath strobes
  typedef struct packed {
    logic              advance;
    logic              wrLo;
    logic              wrHi;
    logic              snap;
    logic [1:0]        tap;
    logic [BYTE_W-1:0] wrByte;
  } dpStrb_t;

  // datapath -> control events
  typedef struct packed {
    logic mainWrap;
    logic midWrap;
  } dpEvt_t;
endpackage

// File: rtl/tcb_prescale.sv
`timescale 1ns/1ps
module tcb_prescale #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic inc,
  output logic tick
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;

  logic [W-1:0] cnt;

  assign tick = inc && (cnt == W'(DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= tick ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/tcb_ctrl.sv
`timescale 1ns/1ps
module tcb_ctrl
  import tcb_pkg::*;
#(
  parameter int NUM_CH      = 6,
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 4,
  parameter int DIV_EXT     = 8,
  parameter int SYNC_STAGES = 2,
  localparam int FLAG_W     = 2 + NUM_CH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic              timerOvf,
  input  logic              extCount,
  input  logic              extClk,
  input  logic [NUM_CH-1:0] chEvt,
  input  logic [BYTE_W-1:0] cntLo,
  input  logic [BYTE_W-1:0] snapHi,
  input  dpEvt_t            evt,
  output dpStrb_t           strb,
  output logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] en,
  output logic              glbEn,
  output logic              blkEn
);
  logic [2:0] selReg;
  logic       runReg;
  logic [1:0] tapReg;
  logic       selChange;
  logic       tick;
  logic       tDivSlow, tDivFast, tDivExt;
  logic [1:0] extIn, extEdge;
  logic       flagWr;
  logic [FLAG_W-1:0] keepMask, setEv;

  // synchronizers and rising-edge detectors for the two external inputs
  assign extIn = {extClk, extCount};
  for (genvar g = 0; g < 2; g++) begin : gSync
    logic [SYNC_STAGES-1:0] sh;
    logic                   prev;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sh   <= '0;
        prev <= 1'b0;
      end else begin
        if (SYNC_STAGES > 1) sh <= {sh[SYNC_STAGES-2:0], extIn[g]};
        else                 sh <= extIn[g];
        prev <= sh[SYNC_STAGES-1];
      end
    end
    assign extEdge[g] = sh[SYNC_STAGES-1] & ~prev;
  end

  assign selChange = wrEn && (addr == REG_CTRL) && (wrData[2:0] != selReg);

  tcb_prescale #(.DIV(DIV_SLOW)) uDivSlow (
    .clk(clk), .rstN(rstN), .clr(selChange), .inc(1'b1), .tick(tDivSlow));
  tcb_prescale #(.DIV(DIV_FAST)) uDivFast (
    .clk(clk), .rstN(rstN), .clr(selChange), .inc(1'b1), .tick(tDivFast));
  tcb_prescale #(.DIV(DIV_EXT)) uDivExt (
    .clk(clk), .rstN(rstN), .clr(selChange), .inc(extEdge[1]), .tick(tDivExt));

  always_comb begin
    case (selReg)
      SRC_SYS_DIV12: tick = tDivSlow;
      SRC_SYS_DIV4:  tick = tDivFast;
      SRC_TMR_OVF:   tick = timerOvf;
      SRC_EXT_CNT:   tick = extEdge[0];
      SRC_SYS:       tick = 1'b1;
      SRC_EXT_DIV8:  tick = tDivExt;
      default:       tick = 1'b0;
    endcase
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selReg <= '0;
      runReg <= 1'b0;
      tapReg <= '0;
      en     <= '0;
      glbEn  <= 1'b0;
      blkEn  <= 1'b0;
    end else if (wrEn) begin
      case (addr)
        REG_CTRL: begin
          selReg <= wrData[2:0];
          runReg <= wrData[3];
          tapReg <= wrData[5:4];
        end
        REG_EN:  en <= wrData[FLAG_W-1:0];
        REG_GLB: begin
          glbEn <= wrData[0];
          blkEn <= wrData[1];
        end
        default: ;
      endcase
    end
  end

  // sticky flags: write-0 clears, events win over a same-cycle clear
  assign flagWr   = wrEn && (addr == REG_FLAG);
  assign keepMask = flagWr ? wrData[FLAG_W-1:0] : '1;
  assign setEv    = {chEvt, evt.midWrap, evt.mainWrap};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & keepMask) | setEv;
  end

  always_comb begin
    strb.advance = runReg && tick;
    strb.wrLo    = wrEn && (addr == REG_CNT_LO);
    strb.wrHi    = wrEn && (addr == REG_CNT_HI);
    strb.snap    = rdEn && (addr == REG_CNT_LO);
    strb.tap     = tapReg;
    strb.wrByte  = wrData;
  end

  always_comb begin
    case (addr)
      REG_CNT_LO: rdData = cntLo;
      REG_CNT_HI: rdData = snapHi;
      REG_CTRL:   rdData = BYTE_W'({tapReg, runReg, selReg});
      REG_FLAG:   rdData = BYTE_W'(flags);
      REG_EN:     rdData = BYTE_W'(en);
      REG_GLB:    rdData = BYTE_W'({blkEn, glbEn});
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/tcb_datapath.sv
`timescale 1ns/1ps
module tcb_datapath
  import tcb_pkg::*;
#(
  parameter int TAP_BASE = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrb_t          strb,
  output logic [CNT_W-1:0] count,
  output logic [BYTE_W-1:0] snapHi,
  output dpEvt_t           evt
);
  logic [BYTE_W-1:0] cntLo, cntHi;
  logic [CNT_W-1:0]  tapMask;
  logic              step;

  assign count = {cntHi, cntLo};
  assign step  = strb.advance && !strb.wrLo && !strb.wrHi;

  always_comb tapMask = (CNT_W'(1) << (TAP_BASE + int'(strb.tap))) - CNT_W'(1);

  assign evt.mainWrap = step && (&count);
  assign evt.midWrap  = step && ((count & tapMask) == tapMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLo  <= '0;
      cntHi  <= '0;
      snapHi <= '0;
    end else begin
      if (strb.wrLo) cntLo <= strb.wrByte;
      if (strb.wrHi) cntHi <= strb.wrByte;
      if (step) {cntHi, cntLo} <= CNT_W'(count + 1'b1);
      if (strb.snap) snapHi <= cntHi;
    end
  end
endmodule

// File: rtl/tcb_irq.sv
`timescale 1ns/1ps
module tcb_irq #(
  parameter int FLAG_W = 8
) (
  input  logic [FLAG_W-1:0] flags,
  input  logic [FLAG_W-1:0] en,
  input  logic              glbEn,
  input  logic              blkEn,
  output logic              irq
);
  logic [FLAG_W-1:0] srcReq;

  for (genvar i = 0; i < FLAG_W; i++) begin : gSrc
    assign srcReq[i] = flags[i] & en[i];
  end

  assign irq = glbEn && blkEn && (|srcReq);
endmodule

// File: rtl/tick_counter_irq.sv
`timescale 1ns/1ps
module tick_counter_irq
  import tcb_pkg::*;
#(
  parameter int NUM_CH      = 6,
  parameter int TAP_BASE    = 8,
  parameter int DIV_SLOW    = 12,
  parameter int DIV_FAST    = 4,
  parameter int DIV_EXT     = 8,
  parameter int SYNC_STAGES = 2,
  localparam int FLAG_W     = 2 + NUM_CH
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  input  logic              timerOvf,
  input  logic              extCount,
  input  logic              extClk,
  input  logic [NUM_CH-1:0] chEvt,
  output logic [CNT_W-1:0]  count,
  output logic              irq
);
  dpStrb_t           strb;
  dpEvt_t            evt;
  logic [BYTE_W-1:0] snapHi;
  logic [FLAG_W-1:0] flags, en;
  logic              glbEn, blkEn;

  tcb_ctrl #(
    .NUM_CH(NUM_CH), .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST),
    .DIV_EXT(DIV_EXT), .SYNC_STAGES(SYNC_STAGES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .timerOvf(timerOvf),
    .extCount(extCount), .extClk(extClk), .chEvt(chEvt),
    .cntLo(count[BYTE_W-1:0]), .snapHi(snapHi), .evt(evt), .strb(strb),
    .flags(flags), .en(en), .glbEn(glbEn), .blkEn(blkEn)
  );

  tcb_datapath #(.TAP_BASE(TAP_BASE)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .count(count),
    .snapHi(snapHi), .evt(evt)
  );

  tcb_irq #(.FLAG_W(FLAG_W)) uIrq (
    .flags(flags), .en(en), .glbEn(glbEn), .blkEn(blkEn), .irq(irq)
  );
endmodule

// File: rtl/tcb_checker.sv
`timescale 1ns/1ps
module tcb_checker
  import tcb_pkg::*;
#(
  parameter int NUM_CH  = 6,
  localparam int FLAG_W = 2 + NUM_CH
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [NUM_CH-1:0] chEvt,
  input logic [CNT_W-1:0]  count,
  input logic              irq,
  input dpStrb_t           strb,
  input dpEvt_t            evt,
  input logic [FLAG_W-1:0] flags,
  input logic [FLAG_W-1:0] en,
  input logic              glbEn,
  input logic              blkEn
);
  AST_ADVANCE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.wrLo && !strb.wrHi) |=> (count == CNT_W'($past(count) + 1))); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.advance && !strb.wrLo && !strb.wrHi) |=> $stable(count)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    evt.mainWrap |=> (count == '0)); // R9
  AST_MAIN_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    evt.mainWrap |=> flags[0]); // R9
  AST_MID_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    evt.midWrap |=> flags[1]); // R10
  AST_CH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (chEvt != '0) |=> ((flags[FLAG_W-1:2] & $past(chEvt)) == $past(chEvt))); // R11
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == REG_FLAG) |=> ((flags & $past(flags)) == $past(flags))); // R12
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rstN)
    !(glbEn && blkEn) |-> !irq); // R13
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((flags & en) != '0)); // R13
endmodule

bind tick_counter_irq tcb_checker #(.NUM_CH(NUM_CH)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .chEvt(chEvt),
  .count(count), .irq(irq), .strb(strb), .evt(evt), .flags(flags),
  .en(en), .glbEn(glbEn), .blkEn(blkEn)
);

// File: tb/tb_tick_counter_irq.sv
`timescale 1ns/1ps
module tb_tick_counter_irq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic        timerOvf = 1'b0, extCount = 1'b0, extClk = 1'b0;
  logic [5:0]  chEvt = '0;
  logic [15:0] count;
  logic        irq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  localparam int K_COUNT = 0, K_READ = 1, K_IRQ = 2;
  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  logic  obsValid = 1'b0;

  always #2.5 clk = ~clk;

  tick_counter_irq dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .timerOvf(timerOvf),
    .extCount(extCount), .extClk(extClk), .chEvt(chEvt),
    .count(count), .irq(irq)
  );

  // monitor: samples 2 ns after each rising edge, pops the expected item
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (obsValid && q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = q.pop_front();
        case (it.kind)
          K_COUNT: act = count;
          K_READ:  act = {8'h00, rdData};
          default: act = {15'd0, irq};
        endcase
        nChecks++;
        if (act !== it.exp) begin
          nFails++;
          $display("FAIL %s: actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
        end
      end
    end
  end

  // all driver tasks start and end at a falling edge
  task automatic push(int kind, logic [15:0] exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
    obsValid = 1'b1;
  endtask

  task automatic wrReg(logic [2:0] a, logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(logic [2:0] a, bit chk, logic [7:0] exp, string tag);
    rdEn = 1'b1; addr = a;
    if (chk) push(K_READ, {8'h00, exp}, tag);
    @(negedge clk);
    rdEn = 1'b0; obsValid = 1'b0;
  endtask

  task automatic expCount(logic [15:0] exp, string tag);
    push(K_COUNT, exp, tag);
    @(negedge clk);
    obsValid = 1'b0;
  endtask

  task automatic expIrq(logic exp, string tag);
    push(K_IRQ, {15'd0, exp}, tag);
    @(negedge clk);
    obsValid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(logic [15:0] v);
    wrReg(3'd0, v[7:0]);
    wrReg(3'd1, v[15:8]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    rdReg(3'd2, 1, 8'h00, "R1 ctrl reset");
    rdReg(3'd3, 1, 8'h00, "R1 flags reset");
    rdReg(3'd4, 1, 8'h00, "R1 enables reset");
    rdReg(3'd5, 1, 8'h00, "R1 global reset");
    expCount(16'h0000, "R1 count reset");
    expIrq(1'b0, "R1 irq reset");

    // R2 system clock source, then stop
    wrReg(3'd2, 8'h0C);
    expCount(16'd1, "R2 first step");
    expCount(16'd2, "R2 second step");
    wrReg(3'd2, 8'h04);
    expCount(16'd3, "R2 stopped");
    idle(5);
    expCount(16'd3, "R2 still held");

    // R3 divide by 12 with prescaler restart
    load(16'h0000);
    wrReg(3'd2, 8'h08);
    idle(10);
    expCount(16'd0, "R3 before 12th clock");
    expCount(16'd1, "R3 at 12th clock");
    idle(10);
    expCount(16'd1, "R3 before 24th clock");
    expCount(16'd2, "R3 at 24th clock");

    // R4 divide by 4
    wrReg(3'd2, 8'h00);
    load(16'h0000);
    wrReg(3'd2, 8'h09);
    idle(2);
    expCount(16'd0, "R4 before 4th clock");
    expCount(16'd1, "R4 at 4th clock");

    // R5 timer overflow pulses
    wrReg(3'd2, 8'h02);
    load(16'h0000);
    wrReg(3'd2, 8'h0A);
    for (int i = 0; i < 3; i++) begin
      timerOvf = 1'b1;
      @(negedge clk);
      timerOvf = 1'b0;
      idle(2);
    end
    expCount(16'd3, "R5 three overflow pulses");

    // R6 external counting input
    wrReg(3'd2, 8'h03);
    load(16'h0000);
    wrReg(3'd2, 8'h0B);
    for (int i = 0; i < 4; i++) begin
      extCount = 1'b1; idle(3);
      extCount = 1'b0; idle(3);
    end
    idle(4);
    expCount(16'd4, "R6 four external edges");

    // R7 external clock divided by 8
    wrReg(3'd2, 8'h05);
    load(16'h0000);
    wrReg(3'd2, 8'h0D);
    for (int i = 0; i < 20; i++) begin
      extClk = 1'b1; idle(2);
      extClk = 1'b0; idle(2);
    end
    idle(4);
    expCount(16'd2, "R7 twenty edges give two counts");

    // R8 snapshot of high byte on low-byte read
    wrReg(3'd2, 8'h04);
    load(16'h01F0);
    wrReg(3'd2, 8'h0C);
    rdReg(3'd0, 0, 8'h00, "");
    idle(20);
    rdReg(3'd1, 1, 8'h01, "R8 snapshot survives carry");
    rdReg(3'd0, 0, 8'h00, "");
    rdReg(3'd1, 1, 8'h02, "R8 snapshot refreshed");
    wrReg(3'd2, 8'h04);

    // R9 full wrap (tap bit 8 also fires, R10)
    wrReg(3'd3, 8'h00);
    load(16'hFFFE);
    wrReg(3'd2, 8'h0C);
    idle(1);
    wrReg(3'd2, 8'h04);
    expCount(16'h0000, "R9 wrapped to zero");
    rdReg(3'd3, 1, 8'h03, "R9 main and mid flags");

    // R10 tap select bit 9 fires, bit 11 does not
    wrReg(3'd3, 8'h00);
    load(16'h03FE);
    wrReg(3'd2, 8'h1C);
    idle(1);
    wrReg(3'd2, 8'h14);
    rdReg(3'd3, 1, 8'h02, "R10 tap 9 sets mid flag");
    wrReg(3'd3, 8'h00);
    load(16'h03FE);
    wrReg(3'd2, 8'h3C);
    idle(1);
    wrReg(3'd2, 8'h34);
    rdReg(3'd3, 1, 8'h00, "R10 tap 11 no mid flag");
    expCount(16'h0400, "R10 counter did step");

    // R11 channel flags set with enables off
    wrReg(3'd3, 8'h00);
    chEvt = 6'b000101;
    @(negedge clk);
    chEvt = '0;
    rdReg(3'd3, 1, 8'h14, "R11 channel flags set");
    expIrq(1'b0, "R11 no irq with enables off");

    // R12 write-0 clear, write-1 keep, set beats clear
    wrReg(3'd3, 8'hFB);
    rdReg(3'd3, 1, 8'h10, "R12 selective clear");
    wrEn = 1'b1; addr = 3'd3; wrData = 8'h00; chEvt = 6'b000001;
    @(negedge clk);
    wrEn = 1'b0; chEvt = '0;
    rdReg(3'd3, 1, 8'h04, "R12 set wins over clear");

    // R13 enable gating
    wrReg(3'd4, 8'h04);
    wrReg(3'd5, 8'h01);
    expIrq(1'b0, "R13 global only");
    wrReg(3'd5, 8'h02);
    expIrq(1'b0, "R13 block only");
    wrReg(3'd5, 8'h03);
    expIrq(1'b1, "R13 all enables");
    wrReg(3'd4, 8'h08);
    expIrq(1'b0, "R13 enable on unset flag");

    idle(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule